// File: doc/BRIEF.md
# YUV to RGB Colour-Space Converter

This block turns a packed 4:2:2 video stream of limited-range YUV samples into full-range 8-bit RGB. Each input beat is one 32-bit word that holds a pixel pair: two luma samples and one shared chroma pair. A two-bit sequence code says where each byte sits in the word. The block unpacks the word and runs both pixels through a programmable 3x4 fixed-point matrix. Each output channel is a weighted sum of Y, U and V plus an additive constant. The result is rounded and clamped to 0..255. Each output beat carries both RGB pixels.

A small write port loads the twelve matrix registers. After reset these registers hold a limited-range conversion: luma 16..235 and chroma 16..240 map to full-range RGB. A per-beat enable chooses between conversion and a raw pass-through of the unpacked samples. Both the input and output sides use a valid/ready handshake. The datapath is three register stages deep, and a stall at the output holds every stage in place.

Top module: `yuv_rgb_conv`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is low and `in_ready` is high. Reset loads the default matrix of R2.
- R2: The matrix registers are grouped by output channel. Index 0..3 is the green row, 4..7 the red row and 8..11 the blue row. Within a row, the order is Y weight, U weight, V weight, constant. The reset values are G = (1192, -400, -833, 2160), R = (1192, 0, 1634, -3552) and B = (1192, 2066, 0, -4416).
- R3: A weight is the low 13 bits of the written word, read as two's complement with 10 fractional bits. A constant is the low 14 bits, read as two's complement with 4 fractional bits. Higher bits of the word are ignored.
- R4: A write to index 12..15 changes nothing. A write to index 0..11 changes only that register.
- R5: Each channel is Wy*Y + Wu*U + Wv*V + K*64. Y, U and V are unsigned. 512 is added to this sum, which is then shifted arithmetically right by 10, so a value exactly halfway between two integers rounds up.
- R6: After rounding, a value below 0 becomes 0 and a value above 255 becomes 255.
- R7: Let b0 be word bits 7:0 and b3 be bits 31:24. The sequence code names the bytes from b3 down to b0:
  - code 0 is YUYV: b0=V, b1=Y0, b2=U, b3=Y1.
  - code 1 is UYVY: b0=Y0, b1=V, b2=Y1, b3=U.
  - code 2 is YVYU: b0=U, b1=Y0, b2=V, b3=Y1.
  - code 3 is VYUY: b0=Y0, b1=U, b2=Y1, b3=V.
- R8: Both pixels of a beat use the same U and V. Pixel 0 uses Y0 and pixel 1 uses Y1.
- R9: When `conv_en` is low for a beat, each output pixel is {Y, U, V} of that pixel, passed unchanged.
- R10: An output pixel is packed as R in bits 23:16, G in bits 15:8 and B in bits 7:0.
- R11: A beat accepted at a rising edge shows `out_valid` high after the third rising edge, counting the accepting one. `in_ready` is low whenever `out_valid` is high and `out_ready` is low.
- R12: While `out_valid` is high and `out_ready` is low, the output pixels stay stable. No beat is dropped, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Matrix register write strobe |
| cfg_addr | input | 4 | Matrix register index |
| cfg_wdata | input | 32 | Matrix register write data |
| conv_en | input | 1 | Per-beat conversion enable, sampled with the input beat |
| seq_sel | input | 2 | Per-beat byte sequence code |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted at this edge when valid |
| in_word | input | 32 | Packed 4:2:2 pixel pair |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_pix0 | output | 24 | First pixel, RGB |
| out_pix1 | output | 24 | Second pixel, RGB |

## Verification
The hardest situation to create is back-pressure that arrives while all three stages hold different beats. The beats must also differ in sequence code and enable, because a mistake there would pair one beat's samples with another beat's mode. To reach it, the stimulus sends a long back-to-back burst that mixes all four codes with conversion on and off. Meanwhile `out_ready` follows a pseudo-random bit, so stalls start and end with the pipeline at every level of fill. Half-way rounding and the ignored upper register bits are reached by loading a custom matrix whose weights produce sums that land exactly on 0.5.

// File: rtl/yuv_rgb_pkg.sv
`timescale 1ns/100ps
package yuv_rgb_pkg;

    localparam int PIX_W       = 8;
    localparam int COEF_W      = 13;
    localparam int CONST_W     = 14;
    localparam int COEF_FRAC   = 10;
    localparam int CONST_FRAC  = 4;
    localparam int NUM_ROWS    = 3;
    localparam int NUM_COLS    = 4;
    localparam int NUM_PIX     = 2;
    localparam int NUM_REGS    = NUM_ROWS * NUM_COLS;
    localparam int REG_IDX_W   = $clog2(NUM_REGS);
    localparam int WORD_W      = 32;
    localparam int RGB_W       = 3 * PIX_W;
    localparam int ACC_W       = COEF_W + PIX_W + 4;
    localparam int CONST_SHIFT = COEF_FRAC - CONST_FRAC;
    localparam int ROUND_HALF  = 1 << (COEF_FRAC - 1);
    localparam int PIX_MAX     = (1 << PIX_W) - 1;

    localparam int ROW_G = 0;
    localparam int ROW_R = 1;
    localparam int ROW_B = 2;

    typedef enum logic [1:0] {
        MEM_VYUY = 2'd0,
        MEM_YVYU = 2'd1,
        MEM_UYVY = 2'd2,
        MEM_YUYV = 2'd3
    } seq_t;

    typedef struct packed {
        logic [PIX_W-1:0] y0;
        logic [PIX_W-1:0] y1;
        logic [PIX_W-1:0] u;
        logic [PIX_W-1:0] v;
    } yuv_pair_t;

    typedef logic signed [CONST_W-1:0] mreg_t;
    typedef logic signed [ACC_W-1:0]   acc_t;

    function automatic mreg_t reset_value(input int idx);
        case (idx)
            0, 4, 8: return mreg_t'(1192);
            1:       return mreg_t'(-400);
            2:       return mreg_t'(-833);
            3:       return mreg_t'(2160);
            6:       return mreg_t'(1634);
            7:       return mreg_t'(-3552);
            9:       return mreg_t'(2066);
            11:      return mreg_t'(-4416);
            default: return mreg_t'(0);
        endcase
    endfunction

    function automatic mreg_t load_value(input logic [REG_IDX_W-1:0] idx,
                                         input logic [WORD_W-1:0] d);
        if ((int'(idx) % NUM_COLS) == NUM_COLS - 1)
            return mreg_t'(d[CONST_W-1:0]);
        return mreg_t'($signed(d[COEF_W-1:0]));
    endfunction

    function automatic logic [PIX_W-1:0] round_clamp(input acc_t acc);
        acc_t r;
        r = (acc + ACC_W'(ROUND_HALF)) >>> COEF_FRAC;
        if (r < 0)
            return '0;
        else if (r > PIX_MAX)
            return PIX_W'(PIX_MAX);
        return r[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/yuv_rgb_coef_regs.sv
`timescale 1ns/100ps
module yuv_rgb_coef_regs
    import yuv_rgb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] addr,
    input  logic [WORD_W-1:0]    wdata,
    output mreg_t                regs_o [NUM_REGS]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++)
                regs_o[i] <= reset_value(i);
        end else if (we && (int'(addr) < NUM_REGS)) begin
            regs_o[addr] <= load_value(addr, wdata);
        end
    end

endmodule

// File: rtl/yuv_rgb_unpack.sv
`timescale 1ns/100ps
module yuv_rgb_unpack
    import yuv_rgb_pkg::*;
(
    input  seq_t              seq,
    input  logic [WORD_W-1:0] word,
    output yuv_pair_t         pair
);

    logic [PIX_W-1:0] b0, b1, b2, b3;

    assign b0 = word[PIX_W-1:0];
    assign b1 = word[2*PIX_W-1:PIX_W];
    assign b2 = word[3*PIX_W-1:2*PIX_W];
    assign b3 = word[4*PIX_W-1:3*PIX_W];

    always_comb begin
        unique case (seq)
            MEM_VYUY: pair = '{y0: b1, y1: b3, u: b2, v: b0};
            MEM_YVYU: pair = '{y0: b0, y1: b2, u: b3, v: b1};
            MEM_UYVY: pair = '{y0: b1, y1: b3, u: b0, v: b2};
            default:  pair = '{y0: b0, y1: b2, u: b1, v: b3};
        endcase
    end

endmodule

// File: rtl/yuv_rgb_row.sv
`timescale 1ns/100ps
module yuv_rgb_row
    import yuv_rgb_pkg::*;
(
    input  logic [PIX_W-1:0] y,
    input  logic [PIX_W-1:0] u,
    input  logic [PIX_W-1:0] v,
    input  mreg_t            w_y,
    input  mreg_t            w_u,
    input  mreg_t            w_v,
    input  mreg_t            k,
    output acc_t             acc
);

    acc_t py, pu, pv, pk;

    always_comb begin
        py  = ACC_W'(w_y) * ACC_W'($signed({1'b0, y}));
        pu  = ACC_W'(w_u) * ACC_W'($signed({1'b0, u}));
        pv  = ACC_W'(w_v) * ACC_W'($signed({1'b0, v}));
        pk  = ACC_W'(k) <<< CONST_SHIFT;
        acc = py + pu + pv + pk;
    end

endmodule

// File: rtl/yuv_rgb_conv.sv
`timescale 1ns/100ps
module yuv_rgb_conv
    import yuv_rgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              conv_en,
    input  logic [1:0]        seq_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [23:0]       out_pix0,
    output logic [23:0]       out_pix1
);

    mreg_t     coef [NUM_REGS];
    yuv_pair_t unpacked;
    logic      adv;

    logic      s1_vld, s1_conv;
    yuv_pair_t s1_pair;
    logic      s2_vld, s2_conv;
    yuv_pair_t s2_pair;
    acc_t      row_acc [NUM_PIX][NUM_ROWS];
    acc_t      s2_acc  [NUM_PIX][NUM_ROWS];
    logic      s3_vld;
    logic [RGB_W-1:0] pix_next [NUM_PIX];
    logic [RGB_W-1:0] pix_q    [NUM_PIX];

    assign adv       = !s3_vld || out_ready;
    assign in_ready  = adv;
    assign out_valid = s3_vld;
    assign out_pix0  = pix_q[0];
    assign out_pix1  = pix_q[1];

    yuv_rgb_coef_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .regs_o (coef)
    );

    yuv_rgb_unpack u_unpack (
        .seq  (seq_t'(seq_sel)),
        .word (in_word),
        .pair (unpacked)
    );

    // Stage 1: unpacked samples
    always_ff @(posedge clk) begin
        if (rst)
            s1_vld <= 1'b0;
        else if (adv)
            s1_vld <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            s1_pair <= unpacked;
            s1_conv <= conv_en;
        end
    end

    // Matrix rows, one per pixel and channel
    for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
            yuv_rgb_row u_row (
                .y   ((p == 0) ? s1_pair.y0 : s1_pair.y1),
                .u   (s1_pair.u),
                .v   (s1_pair.v),
                .w_y (coef[r*NUM_COLS + 0]),
                .w_u (coef[r*NUM_COLS + 1]),
                .w_v (coef[r*NUM_COLS + 2]),
                .k   (coef[r*NUM_COLS + 3]),
                .acc (row_acc[p][r])
            );
        end
    end

    // Stage 2: accumulated sums
    always_ff @(posedge clk) begin
        if (rst)
            s2_vld <= 1'b0;
        else if (adv)
            s2_vld <= s1_vld;
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            s2_acc  <= row_acc;
            s2_pair <= s1_pair;
            s2_conv <= s1_conv;
        end
    end

    // Stage 3: round, clamp, pack or bypass
    always_comb begin
        logic [PIX_W-1:0] yv;
        for (int p = 0; p < NUM_PIX; p++) begin
            yv = (p == 0) ? s2_pair.y0 : s2_pair.y1;
            if (s2_conv)
                pix_next[p] = {round_clamp(s2_acc[p][ROW_R]),
                               round_clamp(s2_acc[p][ROW_G]),
                               round_clamp(s2_acc[p][ROW_B])};
            else
                pix_next[p] = {yv, s2_pair.u, s2_pair.v};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            s3_vld <= 1'b0;
        else if (adv)
            s3_vld <= s2_vld;
    end

    always_ff @(posedge clk) begin
        if (adv)
            pix_q <= pix_next;
    end

endmodule

// File: rtl/yuv_rgb_conv_chk.sv
`timescale 1ns/100ps
module yuv_rgb_conv_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [23:0] out_pix0,
    input logic [23:0] out_pix1
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !out_valid); // R1

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> ##3 out_valid); // R11

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R11

    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_pix0) && $stable(out_pix1))); // R12

endmodule

bind yuv_rgb_conv yuv_rgb_conv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix0  (out_pix0),
    .out_pix1  (out_pix1)
);

// File: tb/yuv_rgb_conv_bench.sv
`timescale 1ns/100ps
module yuv_rgb_conv_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        conv_en = 1'b1;
    logic [1:0]  seq_sel = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_pix0, out_pix1;

    always #2.5 clk = ~clk;

    yuv_rgb_conv u_yuv_rgb_conv (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .conv_en(conv_en), .seq_sel(seq_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_pix0(out_pix0), .out_pix1(out_pix1)
    );

    typedef struct {
        logic [23:0] p0;
        logic [23:0] p1;
        int          cyc;
        string       req;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          last_lat = 0;
    bit          stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          mc [12] = '{1192, -400, -833, 2160,
                             1192, 0, 1634, -3552,
                             1192, 2066, 0, -4416};

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= stall_mode ? lfsr[0] : 1'b1;
    end

    function automatic logic [7:0] ch(int row, int y, int u, int v);
        int acc;
        acc = mc[row*4]*y + mc[row*4+1]*u + mc[row*4+2]*v + mc[row*4+3]*64;
        acc = (acc + 512) >>> 10;
        if (acc < 0) return 8'd0;
        if (acc > 255) return 8'd255;
        return acc[7:0];
    endfunction

    function automatic logic [23:0] model(int y, int u, int v, bit en);
        if (!en) return {y[7:0], u[7:0], v[7:0]};
        return {ch(1, y, u, v), ch(0, y, u, v), ch(2, y, u, v)};
    endfunction

    function automatic logic [31:0] pack(int y0, int y1, int u, int v, int seq);
        case (seq)
            0:       return {y1[7:0], u[7:0], y0[7:0], v[7:0]};
            1:       return {u[7:0], y1[7:0], v[7:0], y0[7:0]};
            2:       return {y1[7:0], v[7:0], y0[7:0], u[7:0]};
            default: return {v[7:0], y1[7:0], u[7:0], y0[7:0]};
        endcase
    endfunction

    task automatic send(int y0, int y1, int u, int v, int seq, bit en, string req);
        exp_t e;
        e.p0  = model(y0, u, v, en);
        e.p1  = model(y1, u, v, en);
        e.req = req;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = pack(y0, y1, u, v, seq);
        seq_sel  = seq[1:0];
        conv_en  = en;
        while (1) begin
            #2;
            if (in_ready) begin
                e.cyc = cyc;
                q.push_back(e);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic cfg_write(int idx, logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = idx[3:0];
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 12)
            mc[idx] = (idx % 4 == 3) ? int'($signed(d[13:0])) : int'($signed(d[12:0]));
    endtask

    task automatic check24(logic [23:0] act, logic [23:0] exp, string req, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every output handshake
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R12 extra beat: actual %h expected none", out_pix0);
                end else begin
                    e = q.pop_front();
                    last_lat = cyc - e.cyc;
                    check24(out_pix0, e.p0, e.req, "pixel0");
                    check24(out_pix1, e.p1, e.req, "pixel1");
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #2;
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset state: actual valid=%b ready=%b expected valid=0 ready=1",
                     out_valid, in_ready);
        end

        // Default matrix, memory order Y0 U Y1 V (code 3)
        send(16, 16, 128, 128, 3, 1'b1, "R1");
        send(235, 235, 128, 128, 3, 1'b1, "R2");
        send(81, 145, 90, 240, 3, 1'b1, "R2");
        send(41, 200, 240, 110, 3, 1'b1, "R2");
        send(50, 200, 60, 200, 3, 1'b1, "R8");
        send(82, 82, 90, 240, 3, 1'b1, "R10");
        for (int s = 0; s < 4; s++)
            send(100, 180, 70, 210, s, 1'b1, "R7");
        send(255, 255, 255, 255, 1, 1'b1, "R6");
        send(0, 0, 0, 0, 2, 1'b1, "R6");
        send(255, 0, 0, 255, 0, 1'b1, "R6");
        send(12, 34, 56, 78, 0, 1'b0, "R9");
        send(200, 17, 99, 3, 2, 1'b0, "R9");
        drain();

        // Custom weights with junk in the upper word bits
        cfg_write(0, 32'hFFFF_E200);
        cfg_write(1, 32'h1234_0000);
        cfg_write(2, 32'h8000_0000);
        cfg_write(3, 32'hABCD_3FF0);
        cfg_write(5, 32'h5555_1C00);
        for (int y = 2; y < 8; y++)
            send(y, y + 9, 40, 20, 3, 1'b1, "R5");
        send(3, 250, 200, 128, 1, 1'b1, "R3");
        drain();

        // Out-of-range indices ignored, in-range index affects only itself
        cfg_write(12, 32'h0000_0FFF);
        cfg_write(13, 32'h0000_0FFF);
        cfg_write(15, 32'hFFFF_FFFF);
        send(77, 160, 30, 220, 0, 1'b1, "R4");
        drain();
        cfg_write(8, 32'h0000_0000);
        send(77, 160, 30, 220, 0, 1'b1, "R4");
        drain();

        // Restore defaults then stress with random back-pressure
        cfg_write(0, 32'd1192);
        cfg_write(1, 32'h0000_1E70);
        cfg_write(2, 32'h0000_1CBF);
        cfg_write(3, 32'd2160);
        cfg_write(5, 32'd0);
        cfg_write(8, 32'd1192);
        stall_mode = 1'b1;
        for (int i = 0; i < 40; i++)
            send((i * 37) % 256, (i * 91 + 5) % 256, (i * 53 + 16) % 256,
                 (i * 29 + 100) % 256, i % 4, (i % 5) != 2, "R12");
        drain();
        stall_mode = 1'b0;
        repeat (3) @(negedge clk);

        // Latency on an idle pipeline
        send(120, 60, 140, 90, 3, 1'b1, "R11");
        drain();
        checks++;
        if (last_lat != 3) begin
            errors++;
            $display("FAIL R11 latency: actual %0d expected 3", last_lat);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule